// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Access Protection

This block keeps recently used virtual-to-physical page translations in a small fully associative array. It checks access rights on every lookup. A request presents a virtual address, a read/write flag and the privilege mode. In that same cycle the block compares the virtual page number against every stored tag. On a permitted match it returns the physical address, formed from the stored physical page number and the unchanged page offset.

If no entry matches, the block raises a walk request to an external page table walker and also presents the page number to look up. When the walker finishes, it writes the result through the refill port. The refill goes into the lowest-numbered free slot. If there is no free slot, it goes into the slot named by a round-robin pointer.

If an entry matches but the access is not allowed, the block raises a protection fault. An access is refused when a read hits an entry without read permission, when a write hits an entry without write permission, or when user code touches a kernel-only page. A flush input drops every translation at once.

Top module: `tlb_prot`

## Requirements
- R1: After reset no entry is valid, so any request reports miss_o=1, hit_o=0 and fault_o=0.
- R2: When a request matches a valid entry and the access is permitted, hit_o=1 in the same cycle and pa_o equals the stored physical page number concatenated with va bits [OFF_W-1:0]; pa_o is zero whenever hit_o=0.
- R3: When a request matches no valid entry, miss_o=1, hit_o=0 and fault_o=0, and walk_vpn_o carries va bits [VA_W-1:OFF_W].
- R4: A refill written in one cycle has no effect on lookups in that cycle and is visible to lookups from the next cycle on.
- R5: A read (req_write_i=0) needs the entry's read permission and a write (req_write_i=1) needs its write permission; a refused access gives fault_o=1, hit_o=0, miss_o=0.
- R6: In user mode (req_user_i=1) an entry whose user bit is 0 is kernel-only and gives fault_o=1 with hit_o=0; in kernel mode the user bit is not checked.
- R7: entry_dirty_o reports the dirty bit of the matched entry; a permitted write that hits an entry with the dirty bit clear sets that bit at the next clock edge, while a refused write leaves it clear.
- R8: A refill goes into the lowest-numbered invalid entry whenever one exists, without moving the replacement pointer.
- R9: When every entry is valid, a refill replaces the entry selected by a round-robin pointer that starts at 0 after reset, advances by one per such replacement and wraps after ENTRIES-1.
- R10: flush_i clears every valid bit at the next edge and overrides a refill presented in the same cycle.
- R11: With req_valid_i=0, hit_o, miss_o and fault_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate all entries |
| req_valid_i | input | 1 | Lookup request present |
| req_va_i | input | VA_W | Virtual address |
| req_write_i | input | 1 | 1 = write access, 0 = read |
| req_user_i | input | 1 | 1 = user mode, 0 = kernel mode |
| hit_o | output | 1 | Permitted translation found |
| pa_o | output | PA_W | Physical address, zero unless hit |
| fault_o | output | 1 | Protection violation on a matching entry |
| miss_o | output | 1 | Walk request: no matching entry |
| walk_vpn_o | output | VA_W-OFF_W | Page number for the walker |
| entry_dirty_o | output | 1 | Dirty bit of the matched entry |
| fill_valid_i | input | 1 | Refill strobe |
| fill_vpn_i | input | VA_W-OFF_W | Refill virtual page number |
| fill_ppn_i | input | PA_W-OFF_W | Refill physical page number |
| fill_rd_i | input | 1 | Refill read permission |
| fill_wr_i | input | 1 | Refill write permission |
| fill_dirty_i | input | 1 | Refill dirty bit |
| fill_usr_i | input | 1 | Refill user-accessible bit |

## Verification
The bench targets the permission corner cases. It checks a write against a read-only page, a read against a write-only page, and a user access to a kernel page. A design that checked only the tag would report hits on these, and a design that looked at the mode bit in kernel mode would fault on legal kernel accesses. It also checks that a refused write leaves the dirty bit clear and that a permitted write sets it one cycle later.

Replacement order is probed by overfilling the array, flushing while the pointer sits away from zero, and refilling. A design that took every refill from the pointer, or that reset the pointer on flush, would then evict the wrong page. Refill-versus-lookup timing and flush-versus-refill priority are checked in the cycle they collide.

// File: rtl/tlb_prot_pkg.sv
package tlb_prot_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
    logic dirty;
    logic usr;
  } tlb_perm_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]            valid_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0] tag_i,
  input  logic [VPN_W-1:0]              vpn_i,
  output logic [ENTRIES-1:0]            match_o,
  output logic                          any_o,
  output logic [IDX_W-1:0]              idx_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = valid_i[g] && (tag_i[g] == vpn_i);
  end

  assign any_o = |match_o;

  // at most one line matches, so OR-encode is exact
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (match_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_perm_chk.sv
module tlb_perm_chk
  import tlb_prot_pkg::*;
(
  input  tlb_perm_t perm_i,
  input  logic      write_i,
  input  logic      user_i,
  output logic      ok_o
);
  logic rw_ok, mode_ok;
  assign rw_ok   = write_i ? perm_i.wr : perm_i.rd;
  assign mode_ok = !user_i || perm_i.usr;
  assign ok_o    = rw_ok && mode_ok;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ENTRIES-1:0] valid_i,
  input  logic               alloc_i,
  output logic [IDX_W-1:0]   victim_o
);
  logic [IDX_W-1:0] rr_q, free_idx, rr_nxt;
  logic             full;

  assign full = &valid_i;

  always_comb begin
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_i[i]) free_idx = IDX_W'(i);
    end
  end

  assign rr_nxt   = (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
  assign victim_o = full ? rr_q : free_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rr_q <= '0;
    else if (alloc_i && full) rr_q <= rr_nxt;
  end

  // R8
  first_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !full) |-> !valid_i[victim_o]);

  // R9
  rr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && full) |=> (rr_q == (($past(rr_q) == IDX_W'(ENTRIES - 1)) ? '0 : $past(rr_q) + 1'b1)));

  // R8
  rr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !full) |=> $stable(rr_q));
endmodule

// File: rtl/tlb_prot.sv
module tlb_prot
  import tlb_prot_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int OFF_W   = 12,
  localparam int VPN_W  = VA_W - OFF_W,
  localparam int PPN_W  = PA_W - OFF_W,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_va_i,
  input  logic             req_write_i,
  input  logic             req_user_i,
  output logic             hit_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             fault_o,
  output logic             miss_o,
  output logic [VPN_W-1:0] walk_vpn_o,
  output logic             entry_dirty_o,
  input  logic             fill_valid_i,
  input  logic [VPN_W-1:0] fill_vpn_i,
  input  logic [PPN_W-1:0] fill_ppn_i,
  input  logic             fill_rd_i,
  input  logic             fill_wr_i,
  input  logic             fill_dirty_i,
  input  logic             fill_usr_i
);
  logic [ENTRIES-1:0]            valid_q;
  logic [ENTRIES-1:0][VPN_W-1:0] vpn_q;
  logic [ENTRIES-1:0][PPN_W-1:0] ppn_q;
  tlb_perm_t                     perm_q [ENTRIES];

  logic [ENTRIES-1:0] match_vec;
  logic               match_any, perm_ok, lookup_match, alloc, set_dirty;
  logic [IDX_W-1:0]   hit_idx, victim;
  tlb_perm_t          sel_perm;
  logic [VPN_W-1:0]   req_vpn;

  assign req_vpn = req_va_i[VA_W-1:OFF_W];

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
    .valid_i (valid_q),
    .tag_i   (vpn_q),
    .vpn_i   (req_vpn),
    .match_o (match_vec),
    .any_o   (match_any),
    .idx_o   (hit_idx)
  );

  assign sel_perm = perm_q[hit_idx];

  tlb_perm_chk u_perm (
    .perm_i  (sel_perm),
    .write_i (req_write_i),
    .user_i  (req_user_i),
    .ok_o    (perm_ok)
  );

  assign alloc = fill_valid_i && !flush_i;

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_q),
    .alloc_i  (alloc),
    .victim_o (victim)
  );

  assign lookup_match  = req_valid_i && match_any;
  assign hit_o         = lookup_match && perm_ok;
  assign fault_o       = lookup_match && !perm_ok;
  assign miss_o        = req_valid_i && !match_any;
  assign walk_vpn_o    = req_vpn;
  assign pa_o          = hit_o ? {ppn_q[hit_idx], req_va_i[OFF_W-1:0]} : '0;
  assign entry_dirty_o = lookup_match && sel_perm.dirty;
  assign set_dirty     = hit_o && req_write_i && !sel_perm.dirty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (flush_i) valid_q <= '0;
    else if (alloc)   valid_q[victim] <= 1'b1;
  end

  // refill is assigned last so it overrides a dirty update to the same slot
  always_ff @(posedge clk_i) begin
    if (set_dirty) perm_q[hit_idx].dirty <= 1'b1;
    if (alloc) begin
      vpn_q[victim]  <= fill_vpn_i;
      ppn_q[victim]  <= fill_ppn_i;
      perm_q[victim] <= '{rd: fill_rd_i, wr: fill_wr_i, dirty: fill_dirty_i, usr: fill_usr_i};
    end
  end

  // R2
  single_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_vec));

  // R4
  fill_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc |=> valid_q[$past(victim)]);

  // R7
  dirty_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && req_write_i && !fill_valid_i) |=> perm_q[$past(hit_idx)].dirty);

  // R10
  flush_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));

  // R5
  fault_no_pa_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (pa_o == '0) && !miss_o);
endmodule

// File: tb/tlb_prot_bench.sv
`timescale 1ns/1ps
module tlb_prot_bench;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        flush_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_va_i = '0;
  logic        req_write_i = 1'b0;
  logic        req_user_i = 1'b0;
  logic        hit_o, fault_o, miss_o, entry_dirty_o;
  logic [31:0] pa_o;
  logic [19:0] walk_vpn_o;
  logic        fill_valid_i = 1'b0;
  logic [19:0] fill_vpn_i = '0;
  logic [19:0] fill_ppn_i = '0;
  logic        fill_rd_i = 1'b0, fill_wr_i = 1'b0, fill_dirty_i = 1'b0, fill_usr_i = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  tlb_prot u_tlb_prot (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i),
    .req_valid_i(req_valid_i), .req_va_i(req_va_i), .req_write_i(req_write_i),
    .req_user_i(req_user_i), .hit_o(hit_o), .pa_o(pa_o), .fault_o(fault_o),
    .miss_o(miss_o), .walk_vpn_o(walk_vpn_o), .entry_dirty_o(entry_dirty_o),
    .fill_valid_i(fill_valid_i), .fill_vpn_i(fill_vpn_i), .fill_ppn_i(fill_ppn_i),
    .fill_rd_i(fill_rd_i), .fill_wr_i(fill_wr_i), .fill_dirty_i(fill_dirty_i),
    .fill_usr_i(fill_usr_i)
  );

  typedef struct packed {
    logic [31:0] va;
    logic        wr;
    logic        usr;
    logic [1:0]  res;   // 0 miss, 1 hit, 2 fault
    logic [31:0] pa;
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{32'h0001_0123, 1'b0, 1'b1, 2'd1, 32'hABCD_E123},  // R2
    '{32'h0002_0FFF, 1'b0, 1'b1, 2'd1, 32'h1234_5FFF},  // R2
    '{32'h0002_0000, 1'b1, 1'b1, 2'd2, 32'h0},          // R5 write to read-only
    '{32'h0003_0ABC, 1'b0, 1'b1, 2'd2, 32'h0},          // R6 user on kernel page
    '{32'h0003_0ABC, 1'b1, 1'b0, 2'd1, 32'h0F0F_0ABC},  // R6 kernel ignores user bit
    '{32'h0004_0010, 1'b0, 1'b0, 2'd2, 32'h0},          // R5 read on write-only
    '{32'h0004_0010, 1'b1, 1'b1, 2'd1, 32'h5555_5010},  // R5
    '{32'h0005_0000, 1'b0, 1'b1, 2'd0, 32'h0},          // R3
    '{32'h0001_0000, 1'b0, 1'b0, 2'd1, 32'hABCD_E000}   // R2
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] va, input logic wr, input logic usr);
    @(negedge clk);
    req_valid_i = 1'b1; req_va_i = va; req_write_i = wr; req_user_i = usr;
    #1;
  endtask

  task automatic fill(input logic [19:0] vpn, input logic [19:0] ppn,
                      input logic rd, input logic wr, input logic d, input logic usr);
    @(negedge clk);
    req_valid_i = 1'b0;
    fill_valid_i = 1'b1; fill_vpn_i = vpn; fill_ppn_i = ppn;
    fill_rd_i = rd; fill_wr_i = wr; fill_dirty_i = d; fill_usr_i = usr;
    @(negedge clk);
    fill_valid_i = 1'b0;
  endtask

  task automatic expect_res(input string tag, input logic [1:0] res, input logic [31:0] pa);
    chk(tag, {61'b0, miss_o, hit_o, fault_o}, {61'b0, res == 2'd0, res == 2'd1, res == 2'd2});
    chk(tag, {32'b0, pa_o}, {32'b0, pa});
  endtask

  initial begin
    #1_600_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset state
    look(32'h0000_0000, 1'b0, 1'b0);
    expect_res("R1 reset miss", 2'd0, 32'h0);
    chk("R3 walk vpn", {44'b0, walk_vpn_o}, 64'h0);

    fill(20'h00010, 20'hABCDE, 1, 1, 0, 1);
    fill(20'h00020, 20'h12345, 1, 0, 1, 1);
    fill(20'h00030, 20'h0F0F0, 1, 1, 1, 0);
    fill(20'h00040, 20'h55555, 0, 1, 1, 1);

    for (int k = 0; k < 9; k++) begin
      look(VECS[k].va, VECS[k].wr, VECS[k].usr);
      expect_res($sformatf("R2 R3 R5 R6 vec%0d", k), VECS[k].res, VECS[k].pa);
    end
    look(32'h0005_0000, 1'b0, 1'b0);
    chk("R3 walk vpn", {44'b0, walk_vpn_o}, 64'h50);

    // R7 dirty handling
    look(32'h0002_0000, 1'b1, 1'b0);
    chk("R7 refused write fault", {63'b0, fault_o}, 64'h1);
    look(32'h0001_0004, 1'b0, 1'b1);
    chk("R7 dirty clear", {63'b0, entry_dirty_o}, 64'h0);
    look(32'h0001_0004, 1'b1, 1'b1);
    chk("R7 write hit pre-edge", {62'b0, hit_o, entry_dirty_o}, 64'h2);
    look(32'h0001_0004, 1'b0, 1'b1);
    chk("R7 dirty set", {63'b0, entry_dirty_o}, 64'h1);
    fill(20'h00060, 20'h66666, 1, 0, 0, 1);
    look(32'h0006_0000, 1'b1, 1'b0);
    chk("R7 refused write", {63'b0, fault_o}, 64'h1);
    look(32'h0006_0000, 1'b0, 1'b0);
    chk("R7 dirty stays clear", {62'b0, hit_o, entry_dirty_o}, 64'h2);

    // R11 idle request
    @(negedge clk);
    req_valid_i = 1'b0; req_va_i = 32'h0001_0000; #1;
    chk("R11 idle outputs", {61'b0, hit_o, miss_o, fault_o}, 64'h0);

    // R4 refill timing
    @(negedge clk);
    req_valid_i = 1'b1; req_va_i = 32'h0007_0123; req_write_i = 1'b0; req_user_i = 1'b0;
    fill_valid_i = 1'b1; fill_vpn_i = 20'h00070; fill_ppn_i = 20'h77777;
    fill_rd_i = 1; fill_wr_i = 1; fill_dirty_i = 1; fill_usr_i = 1;
    #1;
    chk("R4 same-cycle miss", {63'b0, miss_o}, 64'h1);
    @(negedge clk);
    fill_valid_i = 1'b0; #1;
    expect_res("R4 next-cycle hit", 2'd1, 32'h7777_7123);

    // R10 flush beats refill
    @(negedge clk);
    req_valid_i = 1'b0; flush_i = 1'b1;
    fill_valid_i = 1'b1; fill_vpn_i = 20'h00080; fill_ppn_i = 20'h88888;
    @(negedge clk);
    flush_i = 1'b0; fill_valid_i = 1'b0;
    look(32'h0001_0000, 1'b0, 1'b0);
    expect_res("R10 flushed entry", 2'd0, 32'h0);
    look(32'h0008_0000, 1'b0, 1'b0);
    expect_res("R10 refill dropped", 2'd0, 32'h0);

    // R9 round-robin once full
    for (int i = 0; i < 32; i++) fill(20'h00100 + 20'(i), 20'h00200 + 20'(i), 1, 1, 1, 1);
    fill(20'h00300, 20'h00301, 1, 1, 1, 1);
    look(32'h0010_0000, 1'b0, 1'b0);
    expect_res("R9 slot0 evicted", 2'd0, 32'h0);
    look(32'h0030_0005, 1'b0, 1'b0);
    expect_res("R9 new entry", 2'd1, 32'h0030_1005);
    look(32'h0010_1000, 1'b0, 1'b0);
    expect_res("R9 slot1 kept", 2'd1, 32'h0020_1000);
    fill(20'h00400, 20'h00401, 1, 1, 1, 1);
    look(32'h0010_1000, 1'b0, 1'b0);
    expect_res("R9 slot1 evicted", 2'd0, 32'h0);
    look(32'h0010_2000, 1'b0, 1'b0);
    expect_res("R9 slot2 kept", 2'd1, 32'h0020_2000);

    // R8 free slots first; pointer kept across flush
    @(negedge clk);
    req_valid_i = 1'b0; flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
    for (int i = 0; i < 32; i++) fill(20'h00500 + 20'(i), 20'h00A00 + 20'(i), 1, 1, 1, 1);
    fill(20'h00600, 20'h00601, 1, 1, 1, 1);
    look(32'h0050_2000, 1'b0, 1'b0);
    expect_res("R8 slot2 evicted", 2'd0, 32'h0);
    look(32'h0050_0000, 1'b0, 1'b0);
    expect_res("R8 slot0 kept", 2'd1, 32'h00A0_0000);
    look(32'h0050_1000, 1'b0, 1'b0);
    expect_res("R8 slot1 kept", 2'd1, 32'h00A0_1000);
    look(32'h0050_3000, 1'b0, 1'b0);
    expect_res("R8 slot3 kept", 2'd1, 32'h00A0_3000);
    look(32'h0060_0ABC, 1'b0, 1'b0);
    expect_res("R8 new entry", 2'd1, 32'h0060_1ABC);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule